// File: doc/BRIEF.md
# Transceiver Function-Control Register Block

This block holds the function-control byte of a USB transceiver that sits behind a register-access link, together with two read-only identification bytes. The one control register is reached at three addresses. One address replaces the whole value. A second address ORs the data into the register. A third address clears every bit that is 1 in the data. A read at any of the three addresses returns the same value. The register's fields drive the low-power, operating-mode, termination and transceiver-select controls directly.

Two bits clear themselves through hardware handshakes. Writing 1 to the reset bit starts a sequence. The block turns the bus around to the PHY (dir high) and pulses a core reset for a fixed number of cycles. It then waits for the core to report completion. After that it releases dir, clears the reset bit, and raises a one-cycle request for a receive-command update. The active-low suspend bit works in a similar way. Writing 0 to it enters low-power mode, and the stop signal from the link sets it back to 1 on its own.

Top module: `phy_fnctl_regs`

## Requirements
- R1: A read at address 04h, 05h or 06h returns the control byte. Its bit 7 always reads 0. The other fields are: bit 6 suspendm (active low), bit 5 reset, bits 4:3 opmode, bit 2 termsel, bits 1:0 xcvrsel. Each field is also driven on its own output port.
- R2: A write to 04h replaces bits 6:0 with the data. A write to 05h ORs the data into the register. A write to 06h clears the bits where the data is 1. Bit 7 of the data is always ignored.
- R3: While synchronous reset is held, and after it is released, the control byte is 41h: suspendm=1, xcvrsel=01b, all other bits 0. In the same state dir, core_rst, rxcmd_req and rd_valid are low.
- R4: Address 02h reads 08h and address 03h reads 15h. Writes to either address change nothing.
- R5: A read of any address outside 02h–06h returns 00h. A write to such an address changes nothing.
- R6: Read data and rd_valid appear on the clock edge after the edge that samples rd_en. Reads are served at all times, including while dir is high.
- R7: When stp is high at a clock edge, suspendm becomes 1 at that edge. This takes priority over a write to the same bit.
- R8: One cycle after the reset bit becomes 1, dir and core_rst go high. core_rst stays high for exactly RST_CYCLES cycles (8 by default). dir then stays high until core_done is sampled high. A core_done pulse that arrives while core_rst is still high is not acted on.
- R9: In the cycle after core_done is sampled, dir is low. The reset bit is cleared at the end of that cycle, and no other bit changes. In the following cycle rxcmd_req is high for exactly one cycle.
- R10: While dir is high, register writes are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| rd_valid | output | 1 | rdata is valid this cycle |
| stp | input | 1 | Stop signal from the link; wakes from low power |
| core_done | input | 1 | Core reset completion pulse |
| dir | output | 1 | Bus direction held by the PHY during a transceiver reset |
| core_rst | output | 1 | Core reset pulse |
| rxcmd_req | output | 1 | One-cycle receive-command update request |
| suspendm | output | 1 | Active-low suspend field |
| reset_bit | output | 1 | Transceiver-reset field |
| opmode | output | 2 | Operating-mode field |
| termsel | output | 1 | Termination-select field |
| xcvrsel | output | 2 | Transceiver-select field |

## Verification
The three write aliases are driven with data patterns that have overlapping and disjoint bits, and bit 7 is set in them. This separates a true replace from an OR or a masked clear, and it shows that the reserved bit never sticks. Each write is read back through a different alias than the one used to write it, so an alias that decodes to the wrong operation shows up as a wrong value. The reset handshake is followed cycle by cycle: the core-reset width is counted, a write is attempted while dir is high, and the gaps between core_done, dir release and the single rxcmd_req cycle are checked. Identification and out-of-range addresses are both written and read, to show that such writes leave the control byte and the constants untouched.

// File: rtl/phy_fnctl_pkg.sv
package phy_fnctl_pkg;
  localparam int A_ID_LO  = 2;
  localparam int A_ID_HI  = 3;
  localparam int A_FC_WR  = 4;
  localparam int A_FC_SET = 5;
  localparam int A_FC_CLR = 6;

  localparam int BIT_RSVD = 7;
  localparam int BIT_SUSP = 6;
  localparam int BIT_RST  = 5;

  localparam logic [7:0] FC_RESET_VAL = 8'h41;

  typedef enum logic [1:0] {OP_NONE, OP_WRITE, OP_SET, OP_CLR} fc_op_e;
  typedef enum logic [1:0] {RS_ZERO, RS_IDLO, RS_IDHI, RS_FC} rd_sel_e;
  typedef enum logic [2:0] {SQ_IDLE, SQ_PULSE, SQ_WAIT, SQ_CLEAR, SQ_RXCMD} seq_st_e;
endpackage

// File: rtl/fnctl_addr_dec.sv
module fnctl_addr_dec
  import phy_fnctl_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output fc_op_e            op,
  output rd_sel_e           rsel
);
  always_comb begin
    op   = OP_NONE;
    rsel = RS_ZERO;
    if (addr == ADDR_W'(A_FC_WR)) begin
      op   = OP_WRITE;
      rsel = RS_FC;
    end else if (addr == ADDR_W'(A_FC_SET)) begin
      op   = OP_SET;
      rsel = RS_FC;
    end else if (addr == ADDR_W'(A_FC_CLR)) begin
      op   = OP_CLR;
      rsel = RS_FC;
    end else if (addr == ADDR_W'(A_ID_LO)) begin
      rsel = RS_IDLO;
    end else if (addr == ADDR_W'(A_ID_HI)) begin
      rsel = RS_IDHI;
    end
  end
endmodule

// File: rtl/fnctl_reset_seq.sv
module fnctl_reset_seq
  import phy_fnctl_pkg::*;
#(
  parameter int RST_CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic reset_bit,
  input  logic core_done,
  output logic dir,
  output logic core_rst,
  output logic clr_reset,
  output logic rxcmd_req
);
  localparam int CNT_W = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RST_CYCLES - 1);

  seq_st_e          state;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SQ_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        SQ_IDLE: if (reset_bit) begin
          state <= SQ_PULSE;
          cnt   <= '0;
        end
        SQ_PULSE: begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_LAST) state <= SQ_WAIT;
        end
        SQ_WAIT:  if (core_done) state <= SQ_CLEAR;
        SQ_CLEAR: state <= SQ_RXCMD;
        default:  state <= SQ_IDLE;
      endcase
    end
  end

  assign core_rst  = (state == SQ_PULSE);
  assign dir       = (state == SQ_PULSE) || (state == SQ_WAIT);
  assign clr_reset = (state == SQ_CLEAR);
  assign rxcmd_req = (state == SQ_RXCMD);
endmodule

// File: rtl/fnctl_reg.sv
module fnctl_reg
  import phy_fnctl_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  fc_op_e       op,
  input  logic [W-1:0] wdata,
  input  logic         wake,
  input  logic         clr_reset,
  output logic [W-1:0] q
);
  logic [W-1:0] nxt;

  for (genvar b = 0; b < W; b++) begin : g_bit
    always_comb begin
      case (op)
        OP_WRITE: nxt[b] = wdata[b];
        OP_SET:   nxt[b] = q[b] | wdata[b];
        OP_CLR:   nxt[b] = q[b] & ~wdata[b];
        default:  nxt[b] = q[b];
      endcase
      if (b == BIT_RSVD)                nxt[b] = 1'b0;
      if (b == BIT_SUSP && wake)        nxt[b] = 1'b1;
      if (b == BIT_RST  && clr_reset)   nxt[b] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= W'(FC_RESET_VAL);
    else     q <= nxt;
  end
endmodule

// File: rtl/phy_fnctl_regs.sv
module phy_fnctl_regs
  import phy_fnctl_pkg::*;
#(
  parameter int         ADDR_W     = 6,
  parameter int         RST_CYCLES = 8,
  parameter logic [7:0] ID_LO_VAL  = 8'h08,
  parameter logic [7:0] ID_HI_VAL  = 8'h15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              rd_valid,
  input  logic              stp,
  input  logic              core_done,
  output logic              dir,
  output logic              core_rst,
  output logic              rxcmd_req,
  output logic              suspendm,
  output logic              reset_bit,
  output logic [1:0]        opmode,
  output logic              termsel,
  output logic [1:0]        xcvrsel
);
  fc_op_e     dec_op, wr_op;
  rd_sel_e    rsel;
  logic [7:0] fc_q;
  logic       clr_reset;

  fnctl_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr (addr),
    .op   (dec_op),
    .rsel (rsel)
  );

  assign wr_op = (wr_en && !dir) ? dec_op : OP_NONE;

  fnctl_reg #(.W(8)) u_reg (
    .clk       (clk),
    .rst       (rst),
    .op        (wr_op),
    .wdata     (wdata),
    .wake      (stp),
    .clr_reset (clr_reset),
    .q         (fc_q)
  );

  fnctl_reset_seq #(.RST_CYCLES(RST_CYCLES)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .reset_bit (fc_q[BIT_RST]),
    .core_done (core_done),
    .dir       (dir),
    .core_rst  (core_rst),
    .clr_reset (clr_reset),
    .rxcmd_req (rxcmd_req)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        case (rsel)
          RS_IDLO: rdata <= ID_LO_VAL;
          RS_IDHI: rdata <= ID_HI_VAL;
          RS_FC:   rdata <= fc_q;
          default: rdata <= 8'h00;
        endcase
      end
    end
  end

  assign suspendm  = fc_q[6];
  assign reset_bit = fc_q[5];
  assign opmode    = fc_q[4:3];
  assign termsel   = fc_q[2];
  assign xcvrsel   = fc_q[1:0];
endmodule

// File: rtl/phy_fnctl_chk.sv
module phy_fnctl_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic       rd_en,
  input logic       stp,
  input logic [7:0] fc,
  input logic [7:0] rdata,
  input logic       rd_valid,
  input logic       dir,
  input logic       core_rst,
  input logic       rxcmd_req
);
  p_reset_value_r3: assert property (@(posedge clk) rst |=> (fc == 8'h41 && !dir && !rd_valid));
  p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (rst) rd_valid |-> !rdata[7]);
  p_rd_latency_r6: assert property (@(posedge clk) disable iff (rst) rd_en |=> rd_valid);
  p_stp_wake_r7: assert property (@(posedge clk) disable iff (rst) stp |=> fc[6]);
  p_core_rst_dir_r8: assert property (@(posedge clk) disable iff (rst) core_rst |-> dir);
  p_rxcmd_release_r9: assert property (@(posedge clk) disable iff (rst) rxcmd_req |-> (!dir && !fc[5]));
  p_rxcmd_single_r9: assert property (@(posedge clk) disable iff (rst) rxcmd_req |=> !rxcmd_req);
  p_write_blocked_r10: assert property (@(posedge clk) disable iff (rst)
    (dir && wr_en && !stp) |=> (fc == $past(fc)));
endmodule

bind phy_fnctl_regs phy_fnctl_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .stp       (stp),
  .fc        (fc_q),
  .rdata     (rdata),
  .rd_valid  (rd_valid),
  .dir       (dir),
  .core_rst  (core_rst),
  .rxcmd_req (rxcmd_req)
);

// File: tb/phy_fnctl_regs_tb.sv
module phy_fnctl_regs_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0, stp = 1'b0, core_done = 1'b0;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       rd_valid, dir, core_rst, rxcmd_req, suspendm, reset_bit, termsel;
  logic [1:0] opmode, xcvrsel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  phy_fnctl_regs u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .stp(stp),
    .core_done(core_done), .dir(dir), .core_rst(core_rst),
    .rxcmd_req(rxcmd_req), .suspendm(suspendm), .reset_bit(reset_bit),
    .opmode(opmode), .termsel(termsel), .xcvrsel(xcvrsel)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as results appear
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        chk("R6 unexpected rd_valid", 1, 0);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(t, rdata, e);
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(t);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R3 reset state
    chk("R3 suspendm", suspendm, 1);
    chk("R3 xcvrsel", xcvrsel, 1);
    chk("R3 opmode", opmode, 0);
    chk("R3 termsel", termsel, 0);
    chk("R3 dir", dir, 0);
    chk("R3 core_rst", core_rst, 0);
    chk("R3 rxcmd_req", rxcmd_req, 0);
    chk("R3 rd_valid", rd_valid, 0);
    rd(6'h04, 8'h41, "R3/R1 read 04h");
    rd(6'h05, 8'h41, "R1 read 05h");
    rd(6'h06, 8'h41, "R1 read 06h");

    // R2 replace, OR, clear through different aliases
    wr(6'h04, 8'h9E);
    chk("R2 opmode after replace", opmode, 3);
    chk("R2 xcvrsel after replace", xcvrsel, 2);
    chk("R2 suspendm after replace", suspendm, 0);
    rd(6'h05, 8'h1E, "R2 replace, bit7 dropped");
    wr(6'h05, 8'hC1);
    rd(6'h06, 8'h5F, "R2 set alias");
    wr(6'h06, 8'h1A);
    rd(6'h04, 8'h45, "R2 clear alias");
    chk("R2 termsel", termsel, 1);
    chk("R2 opmode after clear", opmode, 0);

    // R4 identification constants
    rd(6'h02, 8'h08, "R4 id low");
    rd(6'h03, 8'h15, "R4 id high");
    wr(6'h02, 8'hFF);
    wr(6'h03, 8'h00);
    rd(6'h02, 8'h08, "R4 id low after write");
    rd(6'h03, 8'h15, "R4 id high after write");
    rd(6'h04, 8'h45, "R4 control unchanged by id writes");

    // R5 out-of-range
    rd(6'h07, 8'h00, "R5 read 07h");
    rd(6'h00, 8'h00, "R5 read 00h");
    rd(6'h3F, 8'h00, "R5 read 3Fh");
    wr(6'h07, 8'h00);
    wr(6'h01, 8'hFF);
    rd(6'h04, 8'h45, "R5 control unchanged");

    // R7 suspend and wake
    wr(6'h06, 8'h40);
    chk("R7 suspendm low", suspendm, 0);
    rd(6'h05, 8'h05, "R7 suspended value");
    @(negedge clk); stp = 1'b1;
    @(negedge clk); stp = 1'b0;
    chk("R7 woken by stp", suspendm, 1);

    // R8..R10 transceiver reset handshake
    wr(6'h04, 8'h41);
    wr(6'h05, 8'h20);
    chk("R8 dir not yet", dir, 0);
    @(negedge clk);
    chk("R8 dir high", dir, 1);
    chk("R8 core_rst high", core_rst, 1);
    begin
      int n = 0;
      while (core_rst && n < 50) begin
        n++;
        @(negedge clk);
      end
      chk("R8 core_rst width", n, 8);
    end
    chk("R8 dir held awaiting done", dir, 1);
    rd(6'h04, 8'h61, "R6 read during dir");
    wr(6'h04, 8'h00);
    chk("R10 dir still high", dir, 1);
    core_done = 1'b1;
    @(negedge clk);
    core_done = 1'b0;
    chk("R9 dir released", dir, 0);
    chk("R9 no rxcmd yet", rxcmd_req, 0);
    @(negedge clk);
    chk("R9 rxcmd_req", rxcmd_req, 1);
    chk("R9 reset bit cleared", reset_bit, 0);
    @(negedge clk);
    chk("R9 rxcmd single", rxcmd_req, 0);
    chk("R9 dir stays low", dir, 0);
    rd(6'h06, 8'h41, "R10 blocked write and R9 clear");

    repeat (3) @(negedge clk);
    chk("R6 all reads returned", exp_q.size(), 0);
    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule